// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly

This unit performs the add-compare-select step of one rate-1/2 trellis butterfly. Each input beat carries two predecessor path metrics (`pm_a`, `pm_b`) and one signed branch value `bm`. The unit forms two candidate pairs by adding and subtracting that single branch value. It keeps the larger candidate of each pair as a new survivor metric. For each survivor it also reports a decision bit that says which predecessor won.

A renormalisation value `norm` travels with each beat. It is subtracted from both survivors, so a sequencer can keep metrics bounded by feeding back the running minimum. Any result that falls outside the metric range is clamped to the nearest representable value. The unit accepts a new butterfly on every cycle and returns it one cycle later, so a decoder iteration of 16 butterflies streams through back to back.

Both edges of the unit use a valid/ready stream. A beat is taken when `in_valid` and `in_ready` are both high. A result is held on the outputs until the consumer raises `out_ready`. While a result is stalled, `in_ready` is low. When the result is being drained, or no result is waiting, `in_ready` is high, so back-pressure never adds a bubble.

Top module: `acs_butterfly`

## Requirements
- R1: `out_pm0` equals the saturated value of max(pm_a+bm, pm_b−bm) − norm, with all inputs taken as two's-complement numbers.
- R2: `out_pm1` equals the saturated value of max(pm_a−bm, pm_b+bm) − norm.
- R3: `out_dec0` is 1 when the second candidate of its pair (pm_b−bm) is chosen and 0 when the first (pm_a+bm) is strictly greater. `out_dec1` follows the same rule for pm_b+bm against pm_a−bm. On a tie the decision is 1.
- R4: A result above 2^(PM_W−1)−1 becomes 2^(PM_W−1)−1, and a result below −2^(PM_W−1) becomes −2^(PM_W−1).
- R5: A beat accepted at a clock edge appears at the outputs after that edge with `out_valid` high. After reset `out_valid` is 0 and `in_ready` is 1.
- R6: While `out_valid` is high and `out_ready` is low, all result outputs hold their values, `out_valid` stays high and `in_ready` is low.
- R7: `in_ready` is high whenever `out_ready` is high, so one butterfly per cycle is sustained.
- R8: When no beat is accepted and the held result is consumed, `out_valid` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat |
| pm_a | input | PM_W | First predecessor metric, signed |
| pm_b | input | PM_W | Second predecessor metric, signed |
| bm | input | BM_W | Branch value, signed |
| norm | input | PM_W | Value subtracted from both survivors, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pm0 | output | PM_W | Survivor of pm_a+bm against pm_b−bm |
| out_pm1 | output | PM_W | Survivor of pm_a−bm against pm_b+bm |
| out_dec0 | output | 1 | Decision for out_pm0 (1 = second candidate) |
| out_dec1 | output | 1 | Decision for out_pm1 (1 = second candidate) |

## Verification
Faults in the candidate or comparison logic show up as a wrong survivor or decision bit one cycle after the beat is accepted. The near-tie and clamping corners of a reduced-width instance are the most sensitive points, and a full sweep reaches all of them. A fault in the valid/ready state shows on the next edge: a lost beat, a duplicated beat, or a result that changes while the consumer is stalled. The sweep runs with the consumer always ready, and a directed stall sequence covers the held-output case.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic {
    PICK_FIRST  = 1'b0,
    PICK_SECOND = 1'b1
  } acs_pick_e;

  typedef enum logic {
    LANE_PLUS_A  = 1'b0,
    LANE_MINUS_A = 1'b1
  } acs_lane_e;
endpackage

// File: rtl/acs_sat_norm.sv
module acs_sat_norm #(
  parameter int PM_W = 12
) (
  input  logic signed [PM_W:0]   win_val,
  input  logic signed [PM_W-1:0] norm,
  output logic signed [PM_W-1:0] res
);
  localparam int NW = PM_W + 2;
  localparam logic signed [NW-1:0] MAX_POS = NW'((64'sd1 <<< (PM_W-1)) - 1);
  localparam logic signed [NW-1:0] MIN_NEG = -NW'(64'sd1 <<< (PM_W-1));

  logic signed [NW-1:0] diff;

  always_comb begin
    diff = {win_val[PM_W], win_val} - {{2{norm[PM_W-1]}}, norm};
    if (diff > MAX_POS)
      res = MAX_POS[PM_W-1:0];
    else if (diff < MIN_NEG)
      res = MIN_NEG[PM_W-1:0];
    else
      res = diff[PM_W-1:0];
  end
endmodule

// File: rtl/acs_lane.sv
module acs_lane
  import acs_pkg::*;
#(
  parameter int        PM_W = 12,
  parameter int        BM_W = 8,
  parameter acs_lane_e MODE = LANE_PLUS_A
) (
  input  logic signed [PM_W-1:0] pm_a,
  input  logic signed [PM_W-1:0] pm_b,
  input  logic signed [BM_W-1:0] bm,
  input  logic signed [PM_W-1:0] norm,
  output logic signed [PM_W-1:0] pm_new,
  output acs_pick_e              pick
);
  localparam int CW = PM_W + 1;

  logic signed [CW-1:0] a_ext, b_ext, d_ext;
  logic signed [CW-1:0] cand_first, cand_second, winner;

  assign a_ext = {pm_a[PM_W-1], pm_a};
  assign b_ext = {pm_b[PM_W-1], pm_b};
  assign d_ext = {{(CW-BM_W){bm[BM_W-1]}}, bm};

  generate
    if (MODE == LANE_PLUS_A) begin : g_plus
      assign cand_first  = a_ext + d_ext;
      assign cand_second = b_ext - d_ext;
    end else begin : g_minus
      assign cand_first  = a_ext - d_ext;
      assign cand_second = b_ext + d_ext;
    end
  endgenerate

  always_comb begin
    if (cand_first > cand_second) begin
      pick   = PICK_FIRST;
      winner = cand_first;
    end else begin
      pick   = PICK_SECOND;
      winner = cand_second;
    end
  end

  acs_sat_norm #(.PM_W(PM_W)) u_sat (
    .win_val (winner),
    .norm    (norm),
    .res     (pm_new)
  );
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly
  import acs_pkg::*;
#(
  parameter int PM_W = 12,
  parameter int BM_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [PM_W-1:0] pm_a,
  input  logic signed [PM_W-1:0] pm_b,
  input  logic signed [BM_W-1:0] bm,
  input  logic signed [PM_W-1:0] norm,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [PM_W-1:0] out_pm0,
  output logic signed [PM_W-1:0] out_pm1,
  output logic                   out_dec0,
  output logic                   out_dec1
);
  localparam int LANES = 2;

  logic signed [PM_W-1:0] lane_pm   [LANES];
  acs_pick_e              lane_pick [LANES];
  logic signed [PM_W-1:0] pm_q      [LANES];
  logic                   dec_q     [LANES];
  logic                   valid_q;
  logic                   take;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      acs_lane #(
        .PM_W (PM_W),
        .BM_W (BM_W),
        .MODE (g == 0 ? LANE_PLUS_A : LANE_MINUS_A)
      ) u_lane (
        .pm_a   (pm_a),
        .pm_b   (pm_b),
        .bm     (bm),
        .norm   (norm),
        .pm_new (lane_pm[g]),
        .pick   (lane_pick[g])
      );

      always_ff @(posedge clk) begin
        if (take) begin
          pm_q[g]  <= lane_pm[g];
          dec_q[g] <= (lane_pick[g] == PICK_SECOND);
        end
      end
    end
  endgenerate

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else if (take)
      valid_q <= 1'b1;
    else if (out_ready)
      valid_q <= 1'b0;
  end

  assign out_valid = valid_q;
  assign out_pm0   = pm_q[0];
  assign out_pm1   = pm_q[1];
  assign out_dec0  = dec_q[0];
  assign out_dec1  = dec_q[1];
endmodule

// File: rtl/acs_butterfly_chk.sv
module acs_butterfly_chk #(
  parameter int PM_W = 12,
  parameter int BM_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic signed [PM_W-1:0] pm_a,
  input logic signed [PM_W-1:0] pm_b,
  input logic signed [BM_W-1:0] bm,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic signed [PM_W-1:0] out_pm0,
  input logic signed [PM_W-1:0] out_pm1,
  input logic                   out_dec0,
  input logic                   out_dec1
);
  logic signed [PM_W:0] tie_l, tie_r;
  assign tie_l = {pm_a[PM_W-1], pm_a} + {{(PM_W+1-BM_W){bm[BM_W-1]}}, bm};
  assign tie_r = {pm_b[PM_W-1], pm_b} - {{(PM_W+1-BM_W){bm[BM_W-1]}}, bm};

  assert_accept_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pm0) && $stable(out_pm1)
                                   && $stable(out_dec0) && $stable(out_dec1)));

  assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ready_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  assert_tie_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tie_l == tie_r) |=> out_dec0);
endmodule

bind acs_butterfly acs_butterfly_chk #(.PM_W(PM_W), .BM_W(BM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pm_a      (pm_a),
  .pm_b      (pm_b),
  .bm        (bm),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pm0   (out_pm0),
  .out_pm1   (out_pm1),
  .out_dec0  (out_dec0),
  .out_dec1  (out_dec1)
);

// File: tb/acs_butterfly_test.sv
module acs_butterfly_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 5;
  localparam int BW = 3;
  localparam int PMAX = (1 << (PW-1)) - 1;
  localparam int PMIN = -(1 << (PW-1));
  localparam int DMAX = (1 << (BW-1)) - 1;
  localparam int DMIN = -(1 << (BW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [PW-1:0] pm_a = '0, pm_b = '0, norm = '0;
  logic signed [BW-1:0] bm = '0;
  logic in_ready, out_valid, out_dec0, out_dec1;
  logic signed [PW-1:0] out_pm0, out_pm1;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int e_pm0, e_pm1, e_d0, e_d1;
  bit e_sat0, e_sat1;

  always #(CLK_PERIOD/2) clk = ~clk;

  acs_butterfly #(.PM_W(PW), .BM_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pm_a(pm_a), .pm_b(pm_b), .bm(bm), .norm(norm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pm0(out_pm0), .out_pm1(out_pm1), .out_dec0(out_dec0), .out_dec1(out_dec1)
  );

  function automatic int clampv(int v, output bit s);
    s = 1'b0;
    if (v > PMAX) begin s = 1'b1; return PMAX; end
    if (v < PMIN) begin s = 1'b1; return PMIN; end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_of(int a, int b, int d, int n);
    int f0, s0, f1, s1;
    f0 = a + d; s0 = b - d;
    f1 = a - d; s1 = b + d;
    e_d0 = (f0 > s0) ? 0 : 1;
    e_d1 = (f1 > s1) ? 0 : 1;
    e_pm0 = clampv(((f0 > s0) ? f0 : s0) - n, e_sat0);
    e_pm1 = clampv(((f1 > s1) ? f1 : s1) - n, e_sat1);
  endtask

  task automatic check_out();
    check("R5 out_valid", int'(out_valid), 1);
    check(e_sat0 ? "R4 out_pm0" : "R1 out_pm0", int'(out_pm0), e_pm0);
    check(e_sat1 ? "R4 out_pm1" : "R2 out_pm1", int'(out_pm1), e_pm1);
    check("R3 out_dec0", int'(out_dec0), e_d0);
    check("R3 out_dec1", int'(out_dec1), e_d1);
  endtask

  task automatic drive(int a, int b, int d, int n);
    pm_a = PW'(a); pm_b = PW'(b); bm = BW'(d); norm = PW'(n);
    in_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int nvals[3];
    bit have;
    nvals[0] = 0; nvals[1] = 7; nvals[2] = -9;
    repeat (3) @(negedge clk);
    check("R5 reset out_valid", int'(out_valid), 0);
    check("R5 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Full sweep, consumer always ready: one beat per cycle (R7)
    have = 0;
    for (int ni = 0; ni < 3; ni++)
      for (int a = PMIN; a <= PMAX; a++)
        for (int b = PMIN; b <= PMAX; b++)
          for (int d = DMIN; d <= DMAX; d++) begin
            if (have) check_out();
            check("R7 in_ready", int'(in_ready), 1);
            drive(a, b, d, nvals[ni]);
            expect_of(a, b, d, nvals[ni]);
            have = 1;
            @(negedge clk);
          end
    check_out();

    // No new beat while draining: out_valid clears (R8)
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 out_valid", int'(out_valid), 0);

    // Stall: hold result and block input (R6)
    drive(3, -2, 1, 0);
    expect_of(3, -2, 1, 0);
    out_ready = 1'b0;
    @(negedge clk);
    check_out();
    check("R6 in_ready", int'(in_ready), 0);
    drive(-7, 6, -3, 2);
    @(negedge clk);
    check_out();
    check("R6 in_ready", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    expect_of(-7, 6, -3, 2);
    check_out();
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 out_valid", int'(out_valid), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule